// File: doc/BRIEF.md
# Landing-Pad Control-Flow Checker

This block enforces forward-edge control-flow integrity at instruction retirement. An indirect jump that retires while the feature is enabled leaves the core in a "landing pad expected" state. The next instruction to retire must then be a landing pad, and that pad must sit on a four-byte boundary. If the pad carries a nonzero 20-bit label, the label must also equal the upper field of the guard register (general register x7, bits 31:12). Any violation produces a one-cycle software-check exception request that carries a fixed cause code.

Three kinds of indirect jump are exempt and do not leave a pad expected: jumps through the return-address register x1, through the alternate link register x5, and through the software-guarded register x7. A landing pad that retires when no pad is expected is an ordinary no-op. The retire stage reports each retiring instruction's class, the source register of a jump, the pad's PC and label, and the current value of x7. Trap delivery and the privilege-level logic that drives the enable input sit outside this block.

Top module: `lpad_cfi_guard`

## Requirements
- R1: While `rst` is high, and on the first sample after it falls, `pad_expected` and `swchk_valid` are 0 and `swchk_cause` is 0.
- R2: With `cfi_en` high and no pad expected, a retire of class 2'b01 (indirect jump) whose source index is not 1, 5 or 7 sets `pad_expected` after the clock edge that samples it. The flag then holds through cycles in which `retire_valid` is low.
- R3: An indirect jump whose source index is 1, 5 or 7 leaves `pad_expected` clear.
- R4: A retire of class 2'b10 (landing pad) while no pad is expected raises no exception, whatever its PC or label, and leaves the flag clear.
- R5: A landing pad that retires while a pad is expected clears `pad_expected`.
- R6: An expected landing pad whose PC has bit 1 or bit 0 set raises the exception.
- R7: An expected landing pad with a nonzero label raises the exception when the label differs from bits 31:12 of `guard_reg`. It raises nothing when the two are equal and the PC is aligned.
- R8: An expected landing pad with a zero label skips the label comparison: it raises nothing when its PC is aligned, whatever `guard_reg` holds.
- R9: Any retire whose class is not 2'b10 (including 2'b00, 2'b01 and 2'b11) while a pad is expected raises the exception and clears `pad_expected`. A jump retired in this state does not re-arm the flag.
- R10: `swchk_valid` is registered. It rises on the cycle after the offending retire and stays high for exactly one cycle. While it is high, `swchk_cause` equals `CAUSE_CODE`; at all other times `swchk_cause` is 0.
- R11: While `cfi_en` is low, no retire raises the exception or sets the flag, and any flag that was set is cleared at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_valid | input | 1 | One instruction retires this cycle |
| retire_cls | input | 2 | Class of the retiring instruction: 00 other, 01 indirect jump, 10 landing pad, 11 other |
| jump_src | input | 5 | Source register index of a retiring indirect jump |
| cfi_en | input | 1 | Landing-pad enforcement enabled |
| pad_pc | input | XLEN | PC of the retiring landing pad |
| pad_label | input | LABEL_W | Label embedded in the retiring landing pad |
| guard_reg | input | XLEN | Current value of register x7 |
| swchk_valid | output | 1 | Software-check exception request, one-cycle pulse |
| swchk_cause | output | CAUSE_W | Cause code that accompanies the pulse, 0 otherwise |
| pad_expected | output | 1 | A landing pad is expected next |

## Verification
The bench builds the block with its default parameters: XLEN 32, a 20-bit label field starting at bit 12, two alignment bits and cause code 18. With these values the label field fills the top of x7 exactly, so a mismatch in the most or least significant label bit can be seen at the ports. Both alignment bits can be driven independently. The random phase biases labels toward equality with the guard field, so accepted pads occur about as often as mismatches. It also mixes all four class codes and the exempt source indices, which makes back-to-back jump and fault sequences frequent.

// File: rtl/lpcfi_pkg.sv
package lpcfi_pkg;

    typedef enum logic [1:0] {
        RC_OTHER = 2'b00,
        RC_IJUMP = 2'b01,
        RC_LPAD  = 2'b10,
        RC_RSVD  = 2'b11
    } retire_cls_e;

    localparam int REG_IDX_W = 5;

    localparam logic [REG_IDX_W-1:0] REG_RET_ADDR  = 5'd1;
    localparam logic [REG_IDX_W-1:0] REG_ALT_LINK  = 5'd5;
    localparam logic [REG_IDX_W-1:0] REG_SW_GUARD  = 5'd7;

    typedef struct packed {
        logic arm;      // qualifying indirect jump
        logic pad;      // landing pad retired
        logic non_pad;  // anything else retired
    } retire_evt_t;

    typedef struct packed {
        logic misaligned;
        logic label_bad;
    } pad_fault_t;

    function automatic logic untracked_src(input logic [REG_IDX_W-1:0] idx);
        return (idx == REG_RET_ADDR) || (idx == REG_ALT_LINK) || (idx == REG_SW_GUARD);
    endfunction

    function automatic logic pad_rejected(input pad_fault_t f);
        return f.misaligned | f.label_bad;
    endfunction

endpackage

// File: rtl/lpcfi_event_decode.sv
module lpcfi_event_decode
    import lpcfi_pkg::*;
(
    input  logic                 retire_valid,
    input  logic                 cfi_en,
    input  logic [1:0]           retire_cls,
    input  logic [REG_IDX_W-1:0] jump_src,
    output retire_evt_t          evt
);
    retire_cls_e cls;
    logic        live;

    always_comb begin
        cls         = retire_cls_e'(retire_cls);
        live        = retire_valid & cfi_en;
        evt.arm     = live && (cls == RC_IJUMP) && !untracked_src(jump_src);
        evt.pad     = live && (cls == RC_LPAD);
        evt.non_pad = live && (cls != RC_LPAD);
    end
endmodule

// File: rtl/lpcfi_pad_check.sv
module lpcfi_pad_check
    import lpcfi_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int LABEL_W    = 20,
    parameter int LABEL_LSB  = 12,
    parameter int ALIGN_BITS = 2
) (
    input  logic [XLEN-1:0]    pad_pc,
    input  logic [LABEL_W-1:0] pad_label,
    input  logic [XLEN-1:0]    guard_reg,
    output pad_fault_t         fault
);
    localparam int LABEL_MSB = LABEL_LSB + LABEL_W - 1;

    logic                misaligned;
    logic [LABEL_W-1:0]  guard_field;

    generate
        if (ALIGN_BITS > 0) begin : g_align
            logic unused_pc_high;
            assign misaligned     = |pad_pc[ALIGN_BITS-1:0];
            assign unused_pc_high = ^pad_pc[XLEN-1:ALIGN_BITS];
        end else begin : g_no_align
            logic unused_pc_all;
            assign misaligned    = 1'b0;
            assign unused_pc_all = ^pad_pc;
        end

        if (LABEL_LSB > 0) begin : g_guard_low
            logic unused_guard_low;
            assign unused_guard_low = ^guard_reg[LABEL_LSB-1:0];
        end

        if (LABEL_MSB < XLEN - 1) begin : g_guard_high
            logic unused_guard_high;
            assign unused_guard_high = ^guard_reg[XLEN-1:LABEL_MSB+1];
        end
    endgenerate

    assign guard_field = guard_reg[LABEL_MSB:LABEL_LSB];

    always_comb begin
        fault.misaligned = misaligned;
        // A zero label requests no comparison at all.
        fault.label_bad  = (pad_label != '0) && (pad_label != guard_field);
    end
endmodule

// File: rtl/lpcfi_track.sv
module lpcfi_track
    import lpcfi_pkg::*;
#(
    parameter int          CAUSE_W    = 8,
    parameter int unsigned CAUSE_CODE = 18
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfi_en,
    input  retire_evt_t        evt,
    input  pad_fault_t         pad_fault,
    output logic               expect_q,
    output logic               pulse_q,
    output logic [CAUSE_W-1:0] cause_q
);
    localparam logic [CAUSE_W-1:0] CAUSE_VAL = CAUSE_W'(CAUSE_CODE);

    logic expect_d;
    logic fault_d;

    always_comb begin
        expect_d = expect_q;
        fault_d  = 1'b0;
        if (!cfi_en) begin
            expect_d = 1'b0;
        end else if (expect_q) begin
            if (evt.pad) begin
                expect_d = 1'b0;
                fault_d  = pad_rejected(pad_fault);
            end else if (evt.non_pad) begin
                expect_d = 1'b0;
                fault_d  = 1'b1;
            end
        end else if (evt.arm) begin
            expect_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            expect_q <= 1'b0;
            pulse_q  <= 1'b0;
            cause_q  <= '0;
        end else begin
            expect_q <= expect_d;
            pulse_q  <= fault_d;
            cause_q  <= fault_d ? CAUSE_VAL : '0;
        end
    end
endmodule

// File: rtl/lpad_cfi_guard.sv
module lpad_cfi_guard
    import lpcfi_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter int          LABEL_W    = 20,
    parameter int          LABEL_LSB  = 12,
    parameter int          ALIGN_BITS = 2,
    parameter int          CAUSE_W    = 8,
    parameter int unsigned CAUSE_CODE = 18
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 retire_valid,
    input  logic [1:0]           retire_cls,
    input  logic [REG_IDX_W-1:0] jump_src,
    input  logic                 cfi_en,
    input  logic [XLEN-1:0]      pad_pc,
    input  logic [LABEL_W-1:0]   pad_label,
    input  logic [XLEN-1:0]      guard_reg,
    output logic                 swchk_valid,
    output logic [CAUSE_W-1:0]   swchk_cause,
    output logic                 pad_expected
);
    retire_evt_t evt;
    pad_fault_t  pad_fault;

    lpcfi_event_decode u_decode (
        .retire_valid (retire_valid),
        .cfi_en       (cfi_en),
        .retire_cls   (retire_cls),
        .jump_src     (jump_src),
        .evt          (evt)
    );

    lpcfi_pad_check #(
        .XLEN       (XLEN),
        .LABEL_W    (LABEL_W),
        .LABEL_LSB  (LABEL_LSB),
        .ALIGN_BITS (ALIGN_BITS)
    ) u_pad (
        .pad_pc    (pad_pc),
        .pad_label (pad_label),
        .guard_reg (guard_reg),
        .fault     (pad_fault)
    );

    lpcfi_track #(
        .CAUSE_W    (CAUSE_W),
        .CAUSE_CODE (CAUSE_CODE)
    ) u_track (
        .clk       (clk),
        .rst       (rst),
        .cfi_en    (cfi_en),
        .evt       (evt),
        .pad_fault (pad_fault),
        .expect_q  (pad_expected),
        .pulse_q   (swchk_valid),
        .cause_q   (swchk_cause)
    );
endmodule

// File: rtl/lpad_cfi_guard_sva.sv
module lpad_cfi_guard_sva
    import lpcfi_pkg::*;
#(
    parameter int          CAUSE_W    = 8,
    parameter int unsigned CAUSE_CODE = 18
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 retire_valid,
    input logic [1:0]           retire_cls,
    input logic [REG_IDX_W-1:0] jump_src,
    input logic                 cfi_en,
    input logic                 swchk_valid,
    input logic [CAUSE_W-1:0]   swchk_cause,
    input logic                 pad_expected
);
    logic exempt;
    assign exempt = (jump_src == 5'd1) || (jump_src == 5'd5) || (jump_src == 5'd7);

    a_r2_jump_arms: assert property (@(posedge clk) disable iff (rst)
        (retire_valid && cfi_en && !pad_expected && retire_cls == 2'b01 && !exempt)
        |=> pad_expected);

    a_r3_exempt_src: assert property (@(posedge clk) disable iff (rst)
        (retire_valid && cfi_en && !pad_expected && retire_cls == 2'b01 && exempt)
        |=> !pad_expected);

    a_r4_idle_pad: assert property (@(posedge clk) disable iff (rst)
        (retire_valid && cfi_en && !pad_expected && retire_cls == 2'b10)
        |=> (!swchk_valid && !pad_expected));

    a_r5_pad_clears: assert property (@(posedge clk) disable iff (rst)
        (retire_valid && pad_expected && retire_cls == 2'b10) |=> !pad_expected);

    a_r9_non_pad_faults: assert property (@(posedge clk) disable iff (rst)
        (retire_valid && cfi_en && pad_expected && retire_cls != 2'b10)
        |=> (swchk_valid && !pad_expected));

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        swchk_valid |=> !swchk_valid);

    a_r10_cause_code: assert property (@(posedge clk) disable iff (rst)
        swchk_valid |-> (swchk_cause == CAUSE_W'(CAUSE_CODE)));

    a_r10_cause_idle: assert property (@(posedge clk) disable iff (rst)
        !swchk_valid |-> (swchk_cause == '0));

    a_r11_disabled: assert property (@(posedge clk) disable iff (rst)
        !cfi_en |=> (!pad_expected && !swchk_valid));
endmodule

bind lpad_cfi_guard lpad_cfi_guard_sva #(
    .CAUSE_W    (CAUSE_W),
    .CAUSE_CODE (CAUSE_CODE)
) u_sva (
    .clk          (clk),
    .rst          (rst),
    .retire_valid (retire_valid),
    .retire_cls   (retire_cls),
    .jump_src     (jump_src),
    .cfi_en       (cfi_en),
    .swchk_valid  (swchk_valid),
    .swchk_cause  (swchk_cause),
    .pad_expected (pad_expected)
);

// File: tb/lpad_cfi_guard_bench.sv
module lpad_cfi_guard_bench;
    localparam int XLEN  = 32;
    localparam int LBW   = 20;
    localparam int CW    = 8;
    localparam int CCODE = 18;

    logic            clk = 1'b0;
    logic            rst;
    logic            retire_valid;
    logic [1:0]      retire_cls;
    logic [4:0]      jump_src;
    logic            cfi_en;
    logic [XLEN-1:0] pad_pc;
    logic [LBW-1:0]  pad_label;
    logic [XLEN-1:0] guard_reg;
    logic            swchk_valid;
    logic [CW-1:0]   swchk_cause;
    logic            pad_expected;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;
    bit  exp_flag = 1'b0;

    always #5 clk = ~clk;

    lpad_cfi_guard u_lpad_cfi_guard (
        .clk          (clk),
        .rst          (rst),
        .retire_valid (retire_valid),
        .retire_cls   (retire_cls),
        .jump_src     (jump_src),
        .cfi_en       (cfi_en),
        .pad_pc       (pad_pc),
        .pad_label    (pad_label),
        .guard_reg    (guard_reg),
        .swchk_valid  (swchk_valid),
        .swchk_cause  (swchk_cause),
        .pad_expected (pad_expected)
    );

    function automatic bit m_fault(bit f, bit v, bit [1:0] c, bit e,
                                   bit [31:0] pc, bit [19:0] lab, bit [31:0] x7);
        if (!(e && v && f)) return 1'b0;
        if (c != 2'b10) return 1'b1;
        if (pc[1:0] != 2'b00) return 1'b1;
        return (lab != 20'd0) && (lab != x7[31:12]);
    endfunction

    function automatic bit m_next(bit f, bit v, bit [1:0] c, bit [4:0] s, bit e);
        if (!e) return 1'b0;
        if (!v) return f;
        if (f)  return 1'b0;
        return (c == 2'b01) && !(s == 5'd1 || s == 5'd5 || s == 5'd7);
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Called at a negedge: drive one cycle, then check at the next negedge.
    task automatic step(string req, bit v, bit [1:0] c, bit [4:0] s, bit e,
                        bit [31:0] pc, bit [19:0] lab, bit [31:0] x7);
        bit ep;
        bit ef;
        ep = m_fault(exp_flag, v, c, e, pc, lab, x7);
        ef = m_next(exp_flag, v, c, s, e);
        retire_valid = v; retire_cls = c; jump_src = s; cfi_en = e;
        pad_pc = pc; pad_label = lab; guard_reg = x7;
        @(negedge clk);
        exp_flag = ef;
        check(req, "pad_expected", {31'd0, pad_expected}, {31'd0, ef});
        check(req, "swchk_valid", {31'd0, swchk_valid}, {31'd0, ep});
        check(req, "swchk_cause", {24'd0, swchk_cause}, ep ? CCODE : 0);
    endtask

    task automatic idle(string req);
        step(req, 1'b0, 2'b00, 5'd0, 1'b1, 32'h0, 20'h0, 32'h0);
    endtask

    task automatic arm();
        step("R2", 1'b1, 2'b01, 5'd10, 1'b1, 32'h0, 20'h0, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; retire_valid = 1'b0; retire_cls = 2'b00; jump_src = 5'd0;
        cfi_en = 1'b1; pad_pc = '0; pad_label = '0; guard_reg = '0;
        repeat (3) @(negedge clk);
        check("R1", "pad_expected in reset", {31'd0, pad_expected}, 0);
        check("R1", "swchk_valid in reset", {31'd0, swchk_valid}, 0);
        rst = 1'b0;
        idle("R1");

        // R2: arm and hold through idle cycles, R5/R8: aligned zero-label pad accepted
        arm();
        idle("R2");
        idle("R2");
        step("R5", 1'b1, 2'b10, 5'd0, 1'b1, 32'h100, 20'h0, 32'hFFFF_F000);
        // R3: exempt source registers
        step("R3", 1'b1, 2'b01, 5'd1, 1'b1, 32'h0, 20'h0, 32'h0);
        step("R3", 1'b1, 2'b01, 5'd5, 1'b1, 32'h0, 20'h0, 32'h0);
        step("R3", 1'b1, 2'b01, 5'd7, 1'b1, 32'h0, 20'h0, 32'h0);
        // R2: neighbouring indices do arm
        step("R2", 1'b1, 2'b01, 5'd6, 1'b1, 32'h0, 20'h0, 32'h0);
        step("R8", 1'b1, 2'b10, 5'd0, 1'b1, 32'h0, 20'h0, 32'h0);
        // R4: unexpected pad with bad PC and bad label is a no-op
        step("R4", 1'b1, 2'b10, 5'd0, 1'b1, 32'h103, 20'h12345, 32'h0);
        // R6: each alignment bit, then R10 single-cycle pulse
        arm();
        step("R6", 1'b1, 2'b10, 5'd0, 1'b1, 32'h202, 20'h0, 32'h0);
        idle("R10");
        arm();
        step("R6", 1'b1, 2'b10, 5'd0, 1'b1, 32'h201, 20'h0, 32'h0);
        idle("R10");
        // R7: matching and mismatching labels, MSB and LSB of field
        arm();
        step("R7", 1'b1, 2'b10, 5'd0, 1'b1, 32'h300, 20'hABCDE, 32'hABCD_E5A5);
        arm();
        step("R7", 1'b1, 2'b10, 5'd0, 1'b1, 32'h300, 20'h12345, 32'h1234_4000);
        arm();
        step("R7", 1'b1, 2'b10, 5'd0, 1'b1, 32'h300, 20'h12345, 32'h9234_5000);
        // R8: zero label ignores x7 contents
        arm();
        step("R8", 1'b1, 2'b10, 5'd0, 1'b1, 32'h400, 20'h0, 32'hDEAD_BEEF);
        // R9: non-pad retire while expected, including a jump and class 11
        arm();
        step("R9", 1'b1, 2'b00, 5'd0, 1'b1, 32'h0, 20'h0, 32'h0);
        arm();
        step("R9", 1'b1, 2'b01, 5'd12, 1'b1, 32'h0, 20'h0, 32'h0);
        idle("R9");
        arm();
        step("R9", 1'b1, 2'b11, 5'd0, 1'b1, 32'h0, 20'h0, 32'h0);
        // R11: disable clears flag, blocks arming and faults
        arm();
        step("R11", 1'b0, 2'b00, 5'd0, 1'b0, 32'h0, 20'h0, 32'h0);
        step("R11", 1'b1, 2'b01, 5'd10, 1'b0, 32'h0, 20'h0, 32'h0);
        arm();
        step("R11", 1'b1, 2'b00, 5'd0, 1'b0, 32'h0, 20'h0, 32'h0);
        arm();
        step("R11", 1'b1, 2'b10, 5'd0, 1'b0, 32'h3, 20'h1, 32'h0);

        // Constrained random phase
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4000; i++) begin
            bit        v;
            bit [1:0]  c;
            bit [4:0]  s;
            bit        e;
            bit [31:0] pc;
            bit [19:0] lab;
            bit [31:0] x7;
            v   = ($urandom % 4) != 0;
            c   = 2'($urandom % 4);
            s   = (($urandom % 2) != 0) ? 5'($urandom % 8) : 5'($urandom);
            e   = ($urandom % 10) != 0;
            pc  = (($urandom % 3) == 0) ? $urandom : ($urandom & 32'hFFFF_FFFC);
            x7  = $urandom;
            case ($urandom % 4)
                0:       lab = 20'h0;
                1:       lab = 20'($urandom);
                default: lab = x7[31:12];
            endcase
            step("R10", v, c, s, e, pc, lab, x7);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule